// File: doc/BRIEF.md
# Multi-Window Address Translator

This block is a passive slave on a peripheral-side memory bus. It claims one aligned region of 64 KiB on that bus. Inside the region there are four programmable data windows and one fixed control window. Each data window covers a run of consecutive local byte offsets, and each is tied to a segment in a much larger system memory through a 24-bit base address.

When a local master reads or writes inside a data window, the block looks up the window with the lowest index that holds the address. It subtracts the window start from the offset and adds that 16-bit displacement to the window base. It then places one request on a request/acknowledge system port and holds the local master with a ready signal until the system answers. Window 1 can be switched to a separate register space, where only aligned double-byte accesses are allowed.

Window placement, size, base, permitted directions and the space-select bit are written through a configuration port. A reference that hits no window, runs past the end of its window, breaks the direction rule, or breaks the register-space alignment rule is not forwarded. It completes with zero data and sets a sticky fault flag.

Top module: `win_xlate`

## Requirements
- R1: A strobe whose address bits above bit 15 differ from the REGION parameter (default 4'hA) is ignored: no l_ready, no s_req and no change to fault.
- R2: A forwarded access drives s_addr = (window base + (offset − window start)) mod 2^24, and copies l_we, l_wide and l_wdata onto s_we, s_wide and s_wdata. A read returns s_rdata on l_rdata in the cycle after the edge that samples s_ack. A write returns zero on l_rdata.
- R3: If an offset lies inside several enabled windows, the window with the lowest index is used, including its direction and size rules.
- R4: An access faults if it hits no enabled window (size 0 disables a window) or if its last byte lies past the window's end (l_wide=1 covers the offset and the next byte). A faulting access is not forwarded, and l_ready rises in the next cycle with zero data.
- R5: A write to a window whose write-permit bit is clear faults. A read from a window whose read-permit bit is clear also faults.
- R6: When window 1 has its space-select bit set, s_regsp=1 and s_addr is the zero-extended displacement with no base added. Such an access faults unless l_wide=1 and the displacement is even. The space-select bit written to any other window has no effect (s_regsp stays 0 and the base is added).
- R7: Offsets in [CTRL_OFF, CTRL_OFF+CTRL_LEN) (default 16'hFF00, length 256) belong to the control window. This window takes precedence over the data windows. Its accesses are never forwarded, do not fault, and complete one cycle later with zero data.
- R8: At most one system request is outstanding. s_req and its fields stay stable until s_ack, and strobes are accepted only while no request is pending.
- R9: fault is sticky. A flt_clr pulse clears it, but a fault raised in the same cycle as flt_clr wins.
- R10: A configuration write that lands in the same cycle as an accepted access does not affect that access. The access uses the previous settings, and the new settings apply from the next access.
- R11: Back-to-back accesses to different windows each use the settings of their own window.
- R12: After reset all windows are disabled, and l_ready, s_req and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Window selected for configuration |
| cfg_start | input | 16 | First local offset of the window |
| cfg_size | input | 16 | Window length in bytes, 0 disables |
| cfg_base | input | 24 | System base address |
| cfg_rd_ok | input | 1 | Reads permitted |
| cfg_wr_ok | input | 1 | Writes permitted |
| cfg_regsp | input | 1 | Register-space select (kept for window 1 only) |
| l_valid | input | 1 | One-cycle local access strobe |
| l_we | input | 1 | Local write |
| l_wide | input | 1 | 1 = double-byte, 0 = byte |
| l_addr | input | 20 | Local byte address |
| l_wdata | input | 16 | Local write data |
| l_ready | output | 1 | Local access complete (one-cycle pulse) |
| l_rdata | output | 16 | Local read data, valid with l_ready |
| flt_clr | input | 1 | Clears the sticky fault |
| fault | output | 1 | Sticky fault flag |
| s_req | output | 1 | System request, held until s_ack |
| s_we | output | 1 | System write |
| s_wide | output | 1 | System double-byte access |
| s_regsp | output | 1 | Register space selected |
| s_addr | output | 24 | System address |
| s_wdata | output | 16 | System write data |
| s_ack | input | 1 | System response |
| s_rdata | input | 16 | System read data, valid with s_ack |

## Verification
Two pairs of events can fall in one clock. The first is a configuration write landing on the same edge that accepts a local strobe to the same window. The bench provokes it by driving cfg_we and l_valid together. Its behavioural model predicts the outcome from the settings held before the edge, and it expects the following access to see the new base. The second is flt_clr arriving together with a new faulting strobe. The bench expects fault to stay set, and its per-clock comparison of l_ready, s_req and fault against the model catches any slip by one cycle.

// File: rtl/win_xlate_pkg.sv
package win_xlate_pkg;

    // Displacement and system address widths are fixed by the translation scheme.
    localparam int OFF_W = 16;
    localparam int SYS_W = 24;

    typedef struct packed {
        logic [OFF_W-1:0] start;
        logic [OFF_W-1:0] size;
        logic [SYS_W-1:0] base;
        logic             rd_ok;
        logic             wr_ok;
        logic             regsp;
    } win_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SYS  = 1'b1
    } bus_st_e;

endpackage

// File: rtl/win_cfg_bank.sv
module win_cfg_bank
    import win_xlate_pkg::*;
#(
    parameter int NWIN    = 4,
    parameter int REG_WIN = 1,
    parameter int IDX_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we_i,
    input  logic [IDX_W-1:0]     cfg_idx_i,
    input  win_cfg_t             cfg_i,
    output win_cfg_t [NWIN-1:0]  tab_o
);

    win_cfg_t [NWIN-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < NWIN; i++) begin
            if (cfg_we_i && (cfg_idx_i == IDX_W'(i))) begin
                tab_d[i] = cfg_i;
                // Only the designated window may reach register space.
                if (i != REG_WIN) begin
                    tab_d[i].regsp = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign tab_o = tab_q;

endmodule

// File: rtl/win_decode.sv
module win_decode
    import win_xlate_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int CTRL_OFF = 'hFF00,
    parameter int CTRL_LEN = 'h100
) (
    input  win_cfg_t [NWIN-1:0]  tab_i,
    input  logic [OFF_W-1:0]     off_i,
    input  logic                 we_i,
    input  logic                 wide_i,
    output logic                 ctrl_o,
    output logic                 fwd_o,
    output logic                 bad_o,
    output logic                 regsp_o,
    output logic [SYS_W-1:0]     saddr_o
);

    localparam logic [OFF_W:0] CTRL_LO = (OFF_W+1)'(CTRL_OFF);
    localparam logic [OFF_W:0] CTRL_HI = (OFF_W+1)'(CTRL_OFF + CTRL_LEN);

    logic [NWIN-1:0]  hit;
    logic [OFF_W-1:0] disp [NWIN];

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            assign disp[g] = off_i - tab_i[g].start;
            assign hit[g]  = (tab_i[g].size != '0)
                          && (off_i >= tab_i[g].start)
                          && (disp[g] < tab_i[g].size);
        end
    endgenerate

    win_cfg_t         sel;
    logic [OFF_W-1:0] sel_disp;
    logic             sel_any;
    logic             span_ok;
    logic             dir_ok;
    logic             reg_ok;
    logic [OFF_W:0]   off_x;

    always_comb begin
        sel      = tab_i[0];
        sel_disp = '0;
        sel_any  = 1'b0;
        // Walk downward so the lowest matching index is the one that remains.
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel      = tab_i[i];
                sel_disp = disp[i];
                sel_any  = 1'b1;
            end
        end
    end

    always_comb begin
        off_x   = {1'b0, off_i};
        ctrl_o  = (CTRL_LEN != 0) && (off_x >= CTRL_LO) && (off_x < CTRL_HI);
        span_ok = ({1'b0, sel_disp} + {{OFF_W{1'b0}}, wide_i}) < {1'b0, sel.size};
        dir_ok  = we_i ? sel.wr_ok : sel.rd_ok;
        reg_ok  = !sel.regsp || (wide_i && !sel_disp[0]);
        bad_o   = !ctrl_o && !(sel_any && span_ok && dir_ok && reg_ok);
        fwd_o   = !ctrl_o && !bad_o;
        regsp_o = sel.regsp;
        if (sel.regsp) begin
            saddr_o = {{(SYS_W-OFF_W){1'b0}}, sel_disp};
        end else begin
            saddr_o = sel.base + {{(SYS_W-OFF_W){1'b0}}, sel_disp};
        end
    end

endmodule

// File: rtl/win_bus_fsm.sv
module win_bus_fsm
    import win_xlate_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              ctrl_i,
    input  logic              fwd_i,
    input  logic              bad_i,
    input  logic              we_i,
    input  logic              wide_i,
    input  logic              regsp_i,
    input  logic [SYS_W-1:0]  saddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              flt_clr_i,
    input  logic              s_ack_i,
    input  logic [DATA_W-1:0] s_rdata_i,
    output logic              idle_o,
    output logic              l_ready_o,
    output logic [DATA_W-1:0] l_rdata_o,
    output logic              fault_o,
    output logic              s_req_o,
    output logic              s_we_o,
    output logic              s_wide_o,
    output logic              s_regsp_o,
    output logic [SYS_W-1:0]  s_addr_o,
    output logic [DATA_W-1:0] s_wdata_o
);

    typedef struct packed {
        bus_st_e           st;
        logic              req;
        logic              we;
        logic              wide;
        logic              regsp;
        logic [SYS_W-1:0]  addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ready;
        logic              fault;
    } fsm_t;

    fsm_t n_d, r_q;

    always_comb begin
        n_d       = r_q;
        n_d.ready = 1'b0;
        if (flt_clr_i) begin
            n_d.fault = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (acc_i) begin
                    if (fwd_i) begin
                        n_d.st    = ST_SYS;
                        n_d.req   = 1'b1;
                        n_d.we    = we_i;
                        n_d.wide  = wide_i;
                        n_d.regsp = regsp_i;
                        n_d.addr  = saddr_i;
                        n_d.wdata = wdata_i;
                    end else begin
                        n_d.ready = 1'b1;
                        n_d.rdata = '0;
                        if (bad_i && !ctrl_i) begin
                            n_d.fault = 1'b1;
                        end
                    end
                end
            end
            ST_SYS: begin
                if (s_ack_i) begin
                    n_d.st    = ST_IDLE;
                    n_d.req   = 1'b0;
                    n_d.ready = 1'b1;
                    n_d.rdata = r_q.we ? '0 : s_rdata_i;
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= n_d;
        end
    end

    assign idle_o    = (r_q.st == ST_IDLE);
    assign l_ready_o = r_q.ready;
    assign l_rdata_o = r_q.rdata;
    assign fault_o   = r_q.fault;
    assign s_req_o   = r_q.req;
    assign s_we_o    = r_q.we;
    assign s_wide_o  = r_q.wide;
    assign s_regsp_o = r_q.regsp;
    assign s_addr_o  = r_q.addr;
    assign s_wdata_o = r_q.wdata;

    // R8: a pending request keeps its fields until answered
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req_o && !s_ack_i) |=> (s_req_o && $stable(s_addr_o) && $stable(s_wdata_o) && $stable(s_we_o)));

    // R8: an answered request completes locally on the next cycle
    a_r8_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req_o && s_ack_i) |=> (l_ready_o && !s_req_o));

    // R4: a rejected access is answered without a system request
    a_r4_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && acc_i && !fwd_i) |=> (l_ready_o && !s_req_o && (l_rdata_o == '0)));

    // R9: the fault flag holds until cleared, and a new fault beats a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !flt_clr_i) |=> fault_o);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && acc_i && bad_i) |=> fault_o);

endmodule

// File: rtl/win_xlate.sv
module win_xlate
    import win_xlate_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int REG_WIN  = 1,
    parameter int LA_W     = 20,
    parameter int DATA_W   = 16,
    parameter int REGION   = 'hA,
    parameter int CTRL_OFF = 'hFF00,
    parameter int CTRL_LEN = 'h100,
    localparam int IDX_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int TAG_W   = LA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [OFF_W-1:0]  cfg_start,
    input  logic [OFF_W-1:0]  cfg_size,
    input  logic [SYS_W-1:0]  cfg_base,
    input  logic              cfg_rd_ok,
    input  logic              cfg_wr_ok,
    input  logic              cfg_regsp,
    input  logic              l_valid,
    input  logic              l_we,
    input  logic              l_wide,
    input  logic [LA_W-1:0]   l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic              l_ready,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              flt_clr,
    output logic              fault,
    output logic              s_req,
    output logic              s_we,
    output logic              s_wide,
    output logic              s_regsp,
    output logic [SYS_W-1:0]  s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_ack,
    input  logic [DATA_W-1:0] s_rdata
);

    win_cfg_t            cfg_in;
    win_cfg_t [NWIN-1:0] tab;
    logic                in_region;
    logic                acc;
    logic                dec_ctrl, dec_fwd, dec_bad, dec_regsp;
    logic [SYS_W-1:0]    dec_saddr;
    logic                idle;

    always_comb begin
        cfg_in.start = cfg_start;
        cfg_in.size  = cfg_size;
        cfg_in.base  = cfg_base;
        cfg_in.rd_ok = cfg_rd_ok;
        cfg_in.wr_ok = cfg_wr_ok;
        cfg_in.regsp = cfg_regsp;
    end

    assign in_region = (l_addr[LA_W-1:OFF_W] == TAG_W'(REGION));
    assign acc       = l_valid && in_region;

    win_cfg_bank #(
        .NWIN    (NWIN),
        .REG_WIN (REG_WIN),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we_i  (cfg_we),
        .cfg_idx_i (cfg_idx),
        .cfg_i     (cfg_in),
        .tab_o     (tab)
    );

    win_decode #(
        .NWIN     (NWIN),
        .CTRL_OFF (CTRL_OFF),
        .CTRL_LEN (CTRL_LEN)
    ) u_dec (
        .tab_i   (tab),
        .off_i   (l_addr[OFF_W-1:0]),
        .we_i    (l_we),
        .wide_i  (l_wide),
        .ctrl_o  (dec_ctrl),
        .fwd_o   (dec_fwd),
        .bad_o   (dec_bad),
        .regsp_o (dec_regsp),
        .saddr_o (dec_saddr)
    );

    win_bus_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (acc),
        .ctrl_i     (dec_ctrl),
        .fwd_i      (dec_fwd),
        .bad_i      (dec_bad),
        .we_i       (l_we),
        .wide_i     (l_wide),
        .regsp_i    (dec_regsp),
        .saddr_i    (dec_saddr),
        .wdata_i    (l_wdata),
        .flt_clr_i  (flt_clr),
        .s_ack_i    (s_ack),
        .s_rdata_i  (s_rdata),
        .idle_o     (idle),
        .l_ready_o  (l_ready),
        .l_rdata_o  (l_rdata),
        .fault_o    (fault),
        .s_req_o    (s_req),
        .s_we_o     (s_we),
        .s_wide_o   (s_wide),
        .s_regsp_o  (s_regsp),
        .s_addr_o   (s_addr),
        .s_wdata_o  (s_wdata)
    );

    // R1: a strobe outside the claimed region leaves both buses quiet
    a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && l_valid && !in_region) |=> (!l_ready && !s_req));

    // R7: control-window accesses never reach the system port
    a_r7_ctrl_local: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && acc && dec_ctrl) |=> (l_ready && !s_req && (l_rdata == '0)));

    // R1: a strobe outside the region does not touch the fault flag
    a_r1_fault_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && l_valid && !in_region && !flt_clr) |=> $stable(fault));

endmodule

// File: tb/win_xlate_bench.sv
module win_xlate_bench;

    localparam int REGION   = 'hA;
    localparam int CTRL_OFF = 'hFF00;
    localparam int CTRL_LEN = 'h100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_idx;
    logic [15:0] cfg_start, cfg_size;
    logic [23:0] cfg_base;
    logic        cfg_rd_ok, cfg_wr_ok, cfg_regsp;
    logic        l_valid, l_we, l_wide;
    logic [19:0] l_addr;
    logic [15:0] l_wdata;
    logic        l_ready;
    logic [15:0] l_rdata;
    logic        flt_clr;
    logic        fault;
    logic        s_req, s_we, s_wide, s_regsp;
    logic [23:0] s_addr;
    logic [15:0] s_wdata;
    logic        s_ack;
    logic [15:0] s_rdata;

    always #2 clk = ~clk;

    win_xlate u_win_xlate (.*);

    int checks = 0;
    int errors = 0;
    bit run = 1'b0;
    bit exp_ready = 1'b0;
    bit exp_sreq  = 1'b0;
    bit exp_fault = 1'b0;

    // Shadow of the window settings, plus a staged write not yet applied.
    int sh_start[4], sh_size[4], sh_base[4];
    bit sh_rd[4], sh_wr[4], sh_rs[4];
    int st_idx, st_start, st_size, st_base;
    bit st_rd, st_wr, st_rs;
    logic [15:0] mem [int];

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model's expected handshake state.
    always @(negedge clk) begin
        if (run) begin
            #1;
            chk(l_ready === exp_ready, "R8 l_ready per clock", l_ready, exp_ready);
            chk(s_req === exp_sreq, "R8 s_req per clock", s_req, exp_sreq);
            chk(fault === exp_fault, "R9 fault per clock", fault, exp_fault);
        end
    end

    function automatic logic [15:0] mem_rd(int key);
        if (mem.exists(key)) return mem[key];
        return 16'(key * 7 + 3);
    endfunction

    // kind: 0 ignored, 1 control, 2 fault, 3 forwarded
    task automatic model(input int addr, input bit we, input bit wide,
                         output int kind, output int sa, output bit rs);
        int off, sel, d;
        kind = 3; sa = 0; rs = 1'b0; sel = -1;
        if ((addr >> 16) != REGION) begin kind = 0; return; end
        off = addr & 'hFFFF;
        if (off >= CTRL_OFF && off < CTRL_OFF + CTRL_LEN) begin kind = 1; return; end
        for (int w = 0; w < 4; w++) begin
            if (sel < 0 && sh_size[w] > 0 && off >= sh_start[w] && (off - sh_start[w]) < sh_size[w])
                sel = w;
        end
        if (sel < 0) begin kind = 2; return; end
        d = off - sh_start[sel];
        if (d + int'(wide) >= sh_size[sel]) begin kind = 2; return; end
        if ((we && !sh_wr[sel]) || (!we && !sh_rd[sel])) begin kind = 2; return; end
        rs = sh_rs[sel] && (sel == 1);
        if (rs && (!wide || (d % 2) != 0)) begin kind = 2; return; end
        sa = rs ? d : ((sh_base[sel] + d) & 'hFFFFFF);
    endtask

    task automatic commit_cfg();
        sh_start[st_idx] = st_start; sh_size[st_idx] = st_size; sh_base[st_idx] = st_base;
        sh_rd[st_idx] = st_rd; sh_wr[st_idx] = st_wr; sh_rs[st_idx] = st_rs;
    endtask

    // Drive a configuration write; with hold=1 it is left on the pins for the next access.
    task automatic set_win(int idx, int start, int size, int base, bit rd, bit wr, bit rs, bit hold);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_start = 16'(start); cfg_size = 16'(size);
        cfg_base = 24'(base); cfg_rd_ok = rd; cfg_wr_ok = wr; cfg_regsp = rs;
        st_idx = idx; st_start = start; st_size = size; st_base = base;
        st_rd = rd; st_wr = wr; st_rs = rs;
        if (!hold) begin
            @(negedge clk);
            cfg_we = 1'b0;
            commit_cfg();
        end
    endtask

    task automatic access(string tag, int addr, bit we, bit wide, int wd, int delay);
        int kind, sa, key;
        bit rs, clr;
        logic [15:0] rd;
        model(addr, we, wide, kind, sa, rs);
        clr = flt_clr;
        l_valid = 1'b1; l_addr = 20'(addr); l_we = we; l_wide = wide; l_wdata = 16'(wd);
        @(negedge clk);
        l_valid = 1'b0;
        flt_clr = 1'b0;
        if (cfg_we) begin cfg_we = 1'b0; commit_cfg(); end
        if (kind == 2) exp_fault = 1'b1;
        else if (clr) exp_fault = 1'b0;
        if (kind == 0) begin
            exp_ready = 1'b0; exp_sreq = 1'b0;
            @(negedge clk);
            return;
        end
        if (kind != 3) begin
            exp_ready = 1'b1;
            chk(l_rdata == 16'h0, {tag, " zero data"}, l_rdata, 0);
            @(negedge clk);
            exp_ready = 1'b0;
            return;
        end
        exp_sreq = 1'b1;
        chk(s_addr == 24'(sa), {tag, " s_addr"}, s_addr, sa);
        chk(s_regsp == rs, {tag, " s_regsp"}, s_regsp, rs);
        chk(s_we == we && s_wide == wide, {tag, " s_we/s_wide"}, {s_we, s_wide}, {we, wide});
        if (we) chk(s_wdata == 16'(wd), {tag, " s_wdata"}, s_wdata, wd);
        key = sa + (rs ? (1 << 24) : 0);
        repeat (delay) @(negedge clk);
        rd = mem_rd(key);
        s_ack = 1'b1; s_rdata = rd;
        @(negedge clk);
        s_ack = 1'b0; s_rdata = 16'hDEAD;
        exp_sreq = 1'b0; exp_ready = 1'b1;
        if (we) begin
            mem[key] = 16'(wd);
            chk(l_rdata == 16'h0, {tag, " write returns zero"}, l_rdata, 0);
        end else begin
            chk(l_rdata == rd, {tag, " read data"}, l_rdata, rd);
        end
        @(negedge clk);
        exp_ready = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_start = '0; cfg_size = '0; cfg_base = '0;
        cfg_rd_ok = 1'b0; cfg_wr_ok = 1'b0; cfg_regsp = 1'b0;
        l_valid = 1'b0; l_we = 1'b0; l_wide = 1'b0; l_addr = '0; l_wdata = '0;
        flt_clr = 1'b0; s_ack = 1'b0; s_rdata = '0;
        for (int w = 0; w < 4; w++) begin
            sh_start[w] = 0; sh_size[w] = 0; sh_base[w] = 0; sh_rd[w] = 0; sh_wr[w] = 0; sh_rs[w] = 0;
        end
        repeat (3) @(negedge clk);
        chk(!l_ready && !s_req && !fault, "R12 reset outputs", {l_ready, s_req, fault}, 0);
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);

        // R12: no window enabled after reset, so any data access faults
        access("R12 disabled window", 'hA0104, 1'b0, 1'b1, 0, 0);
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0; exp_fault = 1'b0;
        @(negedge clk);

        set_win(0, 'h0100, 'h40, 'h123400, 1, 1, 0, 0);
        set_win(1, 'h0200, 'h20, 'h00F000, 1, 1, 0, 0);
        set_win(2, 'h0300, 'h100, 'hFFFF80, 1, 0, 0, 0);
        set_win(3, 'h0120, 'h40, 'h500000, 0, 1, 0, 0);

        access("R2 read w0", 'hA0104, 1'b0, 1'b1, 0, 2);
        access("R2 byte write w0", 'hA0105, 1'b1, 1'b0, 'h5A, 0);
        access("R2 wrap w2", 'hA03F0, 1'b0, 1'b1, 0, 1);
        access("R3 overlap picks w0", 'hA0130, 1'b0, 1'b1, 0, 0);
        access("R3 past w0 reaches w3", 'hA0150, 1'b1, 1'b1, 'h1234, 0);
        access("R5 read of write-only w3", 'hA0150, 1'b0, 1'b1, 0, 0);
        access("R5 write of read-only w2", 'hA0310, 1'b1, 1'b1, 'h1, 0);
        access("R4 wide spill at end of w0", 'hA013F, 1'b0, 1'b1, 0, 0);
        access("R4 byte at end of w0", 'hA013F, 1'b0, 1'b0, 0, 0);
        access("R4 outside every window", 'hA0900, 1'b0, 1'b0, 0, 0);
        access("R1 other region ignored", 'h50104, 1'b0, 1'b1, 0, 0);
        access("R7 control read", 'hAFF10, 1'b0, 1'b1, 0, 0);

        // R9: a clear alone drops the flag
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0; exp_fault = 1'b0;
        @(negedge clk);

        access("R7 control write", 'hAFF02, 1'b1, 1'b1, 'hFFFF, 0);
        set_win(2, 'hFE80, 'h100, 'h010000, 1, 1, 0, 0);
        access("R7 control beats w2", 'hAFF04, 1'b0, 1'b1, 0, 0);
        access("R7 w2 below control", 'hAFE84, 1'b0, 1'b1, 0, 0);

        // R6: register space on window 1
        set_win(1, 'h0200, 'h20, 'h00F000, 1, 1, 1, 0);
        access("R6 reg read addr 2", 'hA0202, 1'b0, 1'b1, 0, 1);
        access("R6 reg write addr 0", 'hA0200, 1'b1, 1'b1, 'hBEEF, 0);
        access("R6 reg read back", 'hA0200, 1'b0, 1'b1, 0, 0);
        access("R6 reg byte faults", 'hA0202, 1'b0, 1'b0, 0, 0);
        access("R6 reg odd faults", 'hA0203, 1'b0, 1'b1, 0, 0);
        set_win(0, 'h0100, 'h40, 'h123400, 1, 1, 1, 0);
        access("R6 select ignored on w0", 'hA0108, 1'b0, 1'b1, 0, 0);

        // R10: configuration write and access on the same edge
        set_win(0, 'h0100, 'h40, 'h777700, 1, 1, 0, 1);
        access("R10 same-cycle uses old base", 'hA0110, 1'b0, 1'b1, 0, 0);
        access("R10 next access new base", 'hA0110, 1'b0, 1'b1, 0, 0);

        // R9: a new fault and a clear on the same edge
        flt_clr = 1'b1;
        access("R9 fault beats clear", 'hA0A00, 1'b0, 1'b0, 0, 0);
        flt_clr = 1'b1;
        access("R9 clear with good access", 'hA0110, 1'b0, 1'b1, 0, 0);

        // R11 and R8: interleaved windows with varied response delays
        set_win(1, 'h0200, 'h20, 'h00F000, 1, 1, 0, 0);
        for (int i = 0; i < 8; i++) begin
            int a;
            a = (i % 3 == 0) ? 'hA0100 : ((i % 3 == 1) ? 'hA0200 : 'hA0160);
            access("R11 interleaved write", a + 2 * i, 1'b1, 1'b1, 'h100 + i, i % 4);
        end
        for (int i = 0; i < 8; i++) begin
            int a;
            a = (i % 3 == 0) ? 'hA0100 : ((i % 3 == 1) ? 'hA0200 : 'hA0160);
            access("R11 interleaved read", a + 2 * i, (i % 3 == 2), 1'b1, 'h300 + i, 5 - (i % 4));
        end

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule